// File: doc/BRIEF.md
# Multi-Mode Programmable Register Logic Cell

A single logic cell of a programmable-logic fabric. It receives four sum-of-products terms (`sum_a` to `sum_d`) and a handful of group-wide controls. A static configuration vector assigns each sum term a role, for example register data, K input, clock, preset, reset or output enable, or leaves it as a plain combinatorial signal. The cell holds one storage bit that behaves as a D, T or JK register.

A group-wide type-switch input changes a D-configured cell into a T or a JK register while it is asserted. With this switch the same cell can parallel-load in one cycle and count in the next. The per-cell configuration chooses which of the two alternate types applies.

The cell drives two general outputs. Each one independently selects the register value or one of the combinatorial terms A, B or C. Term D leaves the cell as a pad output enable or as a buried feedback signal. The whole cell runs on one system clock. The register's own clock source (the global clock, term C or term D) is sampled on each system edge, and the selected transition of that source acts as a clock enable.

Top module: `sop_logic_cell`

## Requirements
- R1: While `rst_n` is low the stored bit is 0, and the edge detector's remembered source level is 0.
- R2: Type code `cfg[2:1]`=00 or 11 is D. On a register clock event the bit takes the data input. With no event, and no preset or reset, it holds.
- R3: Type code 01 is T. On a clock event the bit inverts when data is 1 and holds when data is 0.
- R4: Type code 10 is JK, with J = data and K = the K input. On a clock event J/K = 1/1 inverts the bit, 0/0 holds it, 1/0 sets it to 1 and 0/1 clears it to 0.
- R5: While `g_regtype` is 1, a cell with D type code acts as T when `cfg[3]`=0 and as JK when `cfg[3]`=1. `g_regtype` has no effect on cells with type code 01 or 10.
- R6: The register clock source is term C when `cfg[7:6]`=01. Otherwise it is term D when `cfg[9:8]`=01. Otherwise it is `g_clk`. A clock event is a rising change of the sampled source between consecutive system edges when `cfg[10]`=0, and a falling change when `cfg[10]`=1.
- R7: The reset condition is `g_reset`, or term C when `cfg[7:6]`=10. The preset condition is `g_preset`, or term B when `cfg[5:4]`=10. Either one forces the register output in the same cycle without waiting for a clock event, and reset wins over preset. The forced value is stored at the next system edge, so it remains after the condition is released.
- R8: `out1` is selected by `cfg[12:11]` and `out2` by `cfg[14:13]`. Select 00 gives the register output (after preset or reset forcing), 01 gives term A, 10 gives term B and 11 gives term C.
- R9: With `cfg[9:8]`=10, `pad_oe` follows term D and `fb_out` is 0. With 00 or 11, `fb_out` follows term D and `pad_oe` is 1. With 01 (clock role), `pad_oe` is 1 and `fb_out` is 0.
- R10: The register data input is term A only when `cfg[0]`=1, and is 0 otherwise. The K input is term B only when `cfg[5:4]`=01, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 15 | Static configuration vector |
| sum_a | input | 1 | Sum term A |
| sum_b | input | 1 | Sum term B |
| sum_c | input | 1 | Sum term C |
| sum_d | input | 1 | Sum term D |
| g_clk | input | 1 | Group clock, sampled level |
| g_preset | input | 1 | Group preset |
| g_reset | input | 1 | Group reset |
| g_regtype | input | 1 | Group register-type switch |
| out1 | output | 1 | First selectable output |
| out2 | output | 1 | Second selectable output |
| pad_oe | output | 1 | Pad output enable |
| fb_out | output | 1 | Buried feedback output |

## Verification
The selectable outputs, `pad_oe`, `fb_out`, and the effect of preset and reset on the register output are all due in the same cycle as the stimulus. The bench therefore checks them 1 ns after it drives inputs on the falling clock edge, well before the next rising edge. A register update is due at the first rising system edge on which the sampled clock source shows the selected transition. The bench checks that result at the following falling edge, before the next inputs are applied. A behavioural model advances once per rising edge and predicts both sample points, so every cycle is compared twice.

// File: rtl/sop_logic_cell.sv
module sop_logic_cell #(
  parameter int CFG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             sum_a,
  input  logic             sum_b,
  input  logic             sum_c,
  input  logic             sum_d,
  input  logic             g_clk,
  input  logic             g_preset,
  input  logic             g_reset,
  input  logic             g_regtype,
  output logic             out1,
  output logic             out2,
  output logic             pad_oe,
  output logic             fb_out
);

  localparam int A_DATA = 0;
  localparam int TY_LO  = 1;
  localparam int ALT_JK = 3;
  localparam int B_LO   = 4;
  localparam int C_LO   = 6;
  localparam int D_LO   = 8;
  localparam int POL    = 10;
  localparam int O1_LO  = 11;
  localparam int O2_LO  = 13;

  logic [1:0] base_ty, b_role, c_role, d_role;
  logic       is_d_base, eff_t, eff_jk;
  logic       dat, kin, rst_any, pre_any;
  logic       clk_src, src_q, ev;
  logic       q_reg, q_val, nxt;

  assign base_ty = cfg[TY_LO +: 2];
  assign b_role  = cfg[B_LO +: 2];
  assign c_role  = cfg[C_LO +: 2];
  assign d_role  = cfg[D_LO +: 2];

  assign is_d_base = (base_ty != 2'b01) && (base_ty != 2'b10);
  assign eff_t  = (base_ty == 2'b01) || (is_d_base && g_regtype && !cfg[ALT_JK]);
  assign eff_jk = (base_ty == 2'b10) || (is_d_base && g_regtype &&  cfg[ALT_JK]);

  assign dat = cfg[A_DATA] & sum_a;
  assign kin = (b_role == 2'b01) & sum_b;

  assign rst_any = g_reset  | ((c_role == 2'b10) & sum_c);
  assign pre_any = g_preset | ((b_role == 2'b10) & sum_b);

  assign clk_src = (c_role == 2'b01) ? sum_c :
                   (d_role == 2'b01) ? sum_d : g_clk;
  assign ev = cfg[POL] ? (src_q & ~clk_src) : (~src_q & clk_src);

  always_comb begin
    if (eff_jk)     nxt = (dat & ~q_reg) | (~kin & q_reg);
    else if (eff_t) nxt = q_reg ^ dat;
    else            nxt = dat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= 1'b0;
      src_q <= 1'b0;
    end else begin
      src_q <= clk_src;
      if (rst_any)      q_reg <= 1'b0;
      else if (pre_any) q_reg <= 1'b1;
      else if (ev)      q_reg <= nxt;
    end
  end

  assign q_val = rst_any ? 1'b0 : (pre_any ? 1'b1 : q_reg);

  function automatic logic pick(input logic [1:0] s, input logic q,
                                input logic a, input logic b, input logic c);
    case (s)
      2'b00:   return q;
      2'b01:   return a;
      2'b10:   return b;
      default: return c;
    endcase
  endfunction

  assign out1   = pick(cfg[O1_LO +: 2], q_val, sum_a, sum_b, sum_c);
  assign out2   = pick(cfg[O2_LO +: 2], q_val, sum_a, sum_b, sum_c);
  assign pad_oe = (d_role == 2'b10) ? sum_d : 1'b1;
  assign fb_out = (d_role == 2'b00 || d_role == 2'b11) ? sum_d : 1'b0;

endmodule

// File: rtl/sop_logic_cell_chk.sv
module sop_logic_cell_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [14:0] cfg,
  input logic        g_reset,
  input logic        out1,
  input logic        q_reg,
  input logic        ev,
  input logic        eff_t,
  input logic        eff_jk,
  input logic        dat,
  input logic        kin,
  input logic        rst_any,
  input logic        pre_any
);

  AST_RESET_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (g_reset && cfg[12:11] == 2'b00) |-> !out1); // R7

  AST_PRESET_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_any && !rst_any && cfg[12:11] == 2'b00) |-> out1); // R7

  AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !rst_any && !pre_any) |=> $stable(q_reg)); // R2

  AST_T_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && eff_t && !eff_jk && dat && !rst_any && !pre_any) |=> (q_reg != $past(q_reg))); // R3

  AST_JK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && eff_jk && dat && !kin && !rst_any && !pre_any) |=> q_reg); // R4

  AST_JK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && eff_jk && !dat && kin && !rst_any && !pre_any) |=> !q_reg); // R4

endmodule

bind sop_logic_cell sop_logic_cell_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .g_reset(g_reset), .out1(out1),
  .q_reg(q_reg), .ev(ev), .eff_t(eff_t), .eff_jk(eff_jk), .dat(dat),
  .kin(kin), .rst_any(rst_any), .pre_any(pre_any)
);

// File: tb/test_sop_logic_cell.sv
module test_sop_logic_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] cfg_r = '0;
  logic a = 0, b = 0, c = 0, d = 0, gc = 0, gp = 0, gr = 0, gt = 0;
  logic o1, o2, oe, fb;
  int checks = 0;
  int fails = 0;
  logic mq = 0, mprev = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sop_logic_cell i_sop_logic_cell (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_r),
    .sum_a(a), .sum_b(b), .sum_c(c), .sum_d(d),
    .g_clk(gc), .g_preset(gp), .g_reset(gr), .g_regtype(gt),
    .out1(o1), .out2(o2), .pad_oe(oe), .fb_out(fb)
  );

  function automatic logic [14:0] mk(input int ad, input int ty, input int alt,
      input int br, input int cr, input int dr, input int pol, input int s1, input int s2);
    logic [14:0] v;
    v = '0;
    v[0] = ad[0]; v[2:1] = ty[1:0]; v[3] = alt[0]; v[5:4] = br[1:0];
    v[7:6] = cr[1:0]; v[9:8] = dr[1:0]; v[10] = pol[0];
    v[12:11] = s1[1:0]; v[14:13] = s2[1:0];
    return v;
  endfunction

  function automatic logic sel(input logic [1:0] s, input logic q);
    if (s == 0) return q;
    if (s == 1) return a;
    if (s == 2) return b;
    return c;
  endfunction

  task automatic check(input string tag);
    logic rz, pz, eq, e1, e2, eoe, efb;
    rz = gr || (cfg_r[7:6] == 2 && c);
    pz = gp || (cfg_r[5:4] == 2 && b);
    eq = rz ? 1'b0 : (pz ? 1'b1 : mq);
    e1 = sel(cfg_r[12:11], eq);
    e2 = sel(cfg_r[14:13], eq);
    eoe = (cfg_r[9:8] == 2) ? d : 1'b1;
    efb = (cfg_r[9:8] == 0 || cfg_r[9:8] == 3) ? d : 1'b0;
    checks++;
    if ({o1, o2, oe, fb} !== {e1, e2, eoe, efb}) begin
      fails++;
      $display("FAIL %s t=%0t out1,out2,pad_oe,fb_out actual=%b%b%b%b expected=%b%b%b%b",
               tag, $time, o1, o2, oe, fb, e1, e2, eoe, efb);
    end
  endtask

  task automatic model_edge();
    logic rz, pz, src, evt, j, k;
    int ty;
    rz = gr || (cfg_r[7:6] == 2 && c);
    pz = gp || (cfg_r[5:4] == 2 && b);
    if (cfg_r[7:6] == 1) src = c;
    else if (cfg_r[9:8] == 1) src = d;
    else src = gc;
    evt = cfg_r[10] ? (mprev && !src) : (!mprev && src);
    if (cfg_r[2:1] == 1) ty = 1;
    else if (cfg_r[2:1] == 2) ty = 2;
    else if (gt) ty = cfg_r[3] ? 2 : 1;
    else ty = 0;
    j = cfg_r[0] && a;
    k = (cfg_r[5:4] == 1) && b;
    if (rz) mq = 0;
    else if (pz) mq = 1;
    else if (evt) begin
      if (ty == 0) mq = j;
      else if (ty == 1) mq = mq ^ j;
      else if (j && k) mq = !mq;
      else if (j) mq = 1;
      else if (k) mq = 0;
    end
    mprev = src;
  endtask

  // v = {a, b, c, d, g_clk, g_preset, g_reset, g_regtype}
  task automatic step(input string tag, input logic [7:0] v);
    {a, b, c, d, gc, gp, gr, gt} = v;
    #1 check(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic restart(input string tag, input logic [14:0] cf);
    @(negedge clk);
    rst_n = 0;
    cfg_r = cf;
    {a, b, c, d, gc, gp, gr, gt} = '0;
    mq = 0; mprev = 0;
    #1 check(tag);
    @(negedge clk);
    check(tag);
    rst_n = 1;
  endtask

  initial begin
    restart("R1", mk(1,0,0,0,0,0,0,0,0));
    // R2 D register, global clock rising
    step("R2", 8'b1000_1000); step("R2", 8'b0000_0000); step("R2", 8'b0000_0000);
    step("R2", 8'b0000_1000); step("R2", 8'b1000_0000); step("R2", 8'b1000_1000);
    step("R2", 8'b0000_1000); step("R2", 8'b0000_0000);
    // R6 falling polarity
    restart("R6", mk(1,0,0,0,0,0,1,0,0));
    step("R6", 8'b1000_1000); step("R6", 8'b1000_0000); step("R6", 8'b0000_1000);
    step("R6", 8'b0000_1000); step("R6", 8'b0000_0000);
    // R3 T register
    restart("R3", mk(1,1,0,0,0,0,0,0,0));
    step("R3", 8'b1000_1000); step("R3", 8'b1000_0000); step("R3", 8'b1000_1000);
    step("R3", 8'b0000_0000); step("R3", 8'b0000_1000); step("R3", 8'b1000_0000);
    step("R3", 8'b1000_1000);
    // R4 JK register, B as K
    restart("R4", mk(1,2,0,1,0,0,0,0,0));
    step("R4", 8'b1000_1000); step("R4", 8'b0000_0000);
    step("R4", 8'b0000_1000); step("R4", 8'b0100_0000);
    step("R4", 8'b0100_1000); step("R4", 8'b1100_0000);
    step("R4", 8'b1100_1000); step("R4", 8'b1100_0000);
    step("R4", 8'b1100_1000); step("R4", 8'b0000_0000);
    // R5 D switched to T
    restart("R5", mk(1,0,0,1,0,0,0,0,0));
    step("R5", 8'b1000_1001); step("R5", 8'b1000_0001); step("R5", 8'b1000_1001);
    step("R5", 8'b1000_0000); step("R5", 8'b1000_1000); step("R5", 8'b0000_0001);
    step("R5", 8'b0000_1001);
    // R5 D switched to JK
    restart("R5", mk(1,0,1,1,0,0,0,0,0));
    step("R5", 8'b0100_1000); step("R5", 8'b0100_0001); step("R5", 8'b1000_1001);
    step("R5", 8'b0000_0001); step("R5", 8'b0100_1001); step("R5", 8'b1100_0001);
    step("R5", 8'b1100_1001);
    // R5 T base unaffected by type switch
    restart("R5", mk(1,1,1,1,0,0,0,0,0));
    step("R5", 8'b1000_1001); step("R5", 8'b1000_0001); step("R5", 8'b1000_1001);
    step("R5", 8'b0000_0001);
    // R6 term C as clock, g_clk ignored
    restart("R6", mk(1,0,0,0,1,0,0,0,0));
    step("R6", 8'b1000_1000); step("R6", 8'b1000_0000); step("R6", 8'b1010_0000);
    step("R6", 8'b0010_1000); step("R6", 8'b0000_0000); step("R6", 8'b0010_0000);
    // R6 term D as clock, falling
    restart("R6", mk(1,0,0,0,0,1,1,0,0));
    step("R6", 8'b1001_1000); step("R6", 8'b1000_1000); step("R6", 8'b1000_0000);
    step("R6", 8'b0001_0000); step("R6", 8'b0000_0000);
    // R7 group preset/reset
    restart("R7", mk(1,0,0,0,0,0,0,0,0));
    step("R7", 8'b0000_0100); step("R7", 8'b0000_0000); step("R7", 8'b1000_1010);
    step("R7", 8'b1000_0000); step("R7", 8'b0000_0110); step("R7", 8'b0000_0100);
    step("R7", 8'b0000_0000);
    // R7 term B preset, term C reset
    restart("R7", mk(1,0,0,2,2,0,0,0,0));
    step("R7", 8'b0100_0000); step("R7", 8'b0000_0000); step("R7", 8'b0110_0000);
    step("R7", 8'b0010_0000); step("R7", 8'b1000_1000); step("R7", 8'b0000_0000);
    // R8 output selects
    restart("R8", mk(1,0,0,0,0,0,0,1,2));
    step("R8", 8'b1000_0000); step("R8", 8'b0100_0000); step("R8", 8'b1100_0000);
    restart("R8", mk(1,0,0,0,0,0,0,3,0));
    step("R8", 8'b0010_0000); step("R8", 8'b1000_1000); step("R8", 8'b0110_0000);
    restart("R8", mk(1,0,0,0,0,0,0,2,3));
    step("R8", 8'b0100_0000); step("R8", 8'b0010_0000);
    // R9 term D roles
    restart("R9", mk(1,0,0,0,0,2,0,0,0));
    step("R9", 8'b0001_0000); step("R9", 8'b0000_0000);
    restart("R9", mk(1,0,0,0,0,3,0,0,0));
    step("R9", 8'b0001_0000); step("R9", 8'b0000_0000);
    restart("R9", mk(1,0,0,0,0,1,0,0,0));
    step("R9", 8'b0001_0000); step("R9", 8'b0000_0000);
    // R10 A not data -> loads 0; B not K -> JK holds
    restart("R10", mk(0,0,0,0,0,0,0,0,0));
    step("R10", 8'b0000_0100); step("R10", 8'b1000_1000); step("R10", 8'b1000_0000);
    restart("R10", mk(1,2,0,0,0,0,0,0,0));
    step("R10", 8'b1000_1000); step("R10", 8'b0100_0000); step("R10", 8'b0100_1000);
    step("R10", 8'b0000_0000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule